// File: doc/BRIEF.md
# Two-Digit Serial Code Lock Controller

This block is the decision core of a door lock that accepts a two-digit secret, one 2-bit digit per entry strobe. A small matcher inside the block compares the digit inputs against two parameter-set digits and raises a first-digit flag and a second-digit flag. A five-state sequencer uses those flags to follow the entry. After two strobes it ends in either an unlocked state or a rejected state. It stays there until a synchronous reset is applied.

A wrong first digit does not cause an immediate rejection. The sequencer moves to a silent failure state and still takes the second strobe, so the outcome is only visible after both digits have been entered. A parameter chooses the state encoding, either 3-bit binary or one-hot. The behaviour at the ports is the same for both. The strobe input has no back-pressure: the sequencer accepts every single-cycle strobe, so no valid/ready handshake is used. All pins are plain control and status signals.

Top module: `duo_code_lock`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the sequencer goes to its idle state. In the following cycle `unlock_o` and `reject_o` are both 0.
- R2: In the idle state, a cycle with `strobe_i` high and `digit_i` equal to `KEY_A` moves the sequencer to the first-digit-accepted state. Both outputs stay 0.
- R3: In the idle state, a cycle with `strobe_i` high and `digit_i` not equal to `KEY_A` moves the sequencer to the first-digit-failed state. Both outputs stay 0.
- R4: In the first-digit-accepted state, a strobe with `digit_i` equal to `KEY_B` sets `unlock_o`=1 and `reject_o`=0 from the next cycle.
- R5: In the first-digit-accepted state, a strobe with `digit_i` not equal to `KEY_B` sets `reject_o`=1 and `unlock_o`=0 from the next cycle.
- R6: In the first-digit-failed state, any strobe sets `reject_o`=1 and `unlock_o`=0 from the next cycle, whatever the digit is.
- R7: In every state, a cycle without `strobe_i` leaves the state and both outputs unchanged.
- R8: The unlocked and rejected states are absorbing. Further strobes with any digit leave the outputs unchanged until reset.
- R9: `unlock_o` and `reject_o` are never high together. Neither output is high before the second strobe since reset.
- R10: `ONE_HOT`=0 gives 3-bit binary encoding and `ONE_HOT`=1 gives one-hot encoding. Port behaviour is the same for both settings. `KEY_A` must differ from `KEY_B`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Single-cycle digit entry pulse |
| digit_i | input | 2 | Digit value presented with the strobe |
| unlock_o | output | 1 | High in the unlocked state |
| reject_o | output | 1 | High in the rejected state |

## Verification
The checker assumes that `strobe_i` is already a clean single-cycle pulse and that `digit_i` is stable whenever it is sampled with a strobe. It does not assume any minimum gap between strobes, so back-to-back strobes are allowed. The random stimulus sets the strobe in each cycle with a seeded coin toss and draws digits uniformly. It also places resets at random points, so every state sees strobes with both matching and mismatching digits. The bench runs two instances, one per encoding, on the same stimulus and compares both against one reference model.

// File: rtl/duo_code_lock_pkg.sv
package duo_code_lock_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_GOOD1 = 3'd1,
    ST_FAIL1 = 3'd2,
    ST_OPEN = 3'd3,
    ST_DENY = 3'd4
  } lock_state_e;

  localparam int NUM_STATES = 5;
endpackage

// File: rtl/duo_code_match.sv
module duo_code_match #(
  parameter int DW = 2,
  parameter logic [1:0] KEY_A = 2'b01,
  parameter logic [1:0] KEY_B = 2'b11
) (
  input  logic [DW-1:0] digit_i,
  output logic          hit_a_o,
  output logic          hit_b_o
);
  always_comb begin
    hit_a_o = (digit_i == KEY_A[DW-1:0]);
    hit_b_o = (digit_i == KEY_B[DW-1:0]);
  end
endmodule

// File: rtl/duo_code_seq.sv
module duo_code_seq
  import duo_code_lock_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic strobe_i,
  input  logic hit_a_i,
  input  logic hit_b_i,
  output logic unlock_o,
  output logic reject_o
);
  generate
    if (ONE_HOT) begin : g_onehot
      localparam int I_IDLE = 0;
      localparam int I_GOOD1 = 1;
      localparam int I_FAIL1 = 2;
      localparam int I_OPEN = 3;
      localparam int I_DENY = 4;
      logic [NUM_STATES-1:0] st_q, st_d;

      always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= NUM_STATES'(1) << I_IDLE;
        else       st_q <= st_d;
      end

      always_comb begin
        st_d = '0;
        st_d[I_IDLE]  = st_q[I_IDLE] & ~strobe_i;
        st_d[I_GOOD1] = (st_q[I_IDLE] & strobe_i & hit_a_i) |
                        (st_q[I_GOOD1] & ~strobe_i);
        st_d[I_FAIL1] = (st_q[I_IDLE] & strobe_i & ~hit_a_i) |
                        (st_q[I_FAIL1] & ~strobe_i);
        st_d[I_OPEN]  = (st_q[I_GOOD1] & strobe_i & hit_b_i) | st_q[I_OPEN];
        st_d[I_DENY]  = (st_q[I_GOOD1] & strobe_i & ~hit_b_i) |
                        (st_q[I_FAIL1] & strobe_i) | st_q[I_DENY];
      end

      always_comb begin
        unlock_o = st_q[I_OPEN];
        reject_o = st_q[I_DENY];
      end
    end else begin : g_binary
      lock_state_e st_q, st_d;

      always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= ST_IDLE;
        else       st_q <= st_d;
      end

      always_comb begin
        st_d = st_q;
        unique case (st_q)
          ST_IDLE:  if (strobe_i) st_d = hit_a_i ? ST_GOOD1 : ST_FAIL1;
          ST_GOOD1: if (strobe_i) st_d = hit_b_i ? ST_OPEN : ST_DENY;
          ST_FAIL1: if (strobe_i) st_d = ST_DENY;
          ST_OPEN:  st_d = ST_OPEN;
          ST_DENY:  st_d = ST_DENY;
          default:  st_d = ST_IDLE;
        endcase
      end

      always_comb begin
        unlock_o = 1'b0;
        reject_o = 1'b0;
        case (st_q)
          ST_IDLE:  begin unlock_o = 1'b0; reject_o = 1'b0; end
          ST_GOOD1: begin unlock_o = 1'b0; reject_o = 1'b0; end
          ST_FAIL1: begin unlock_o = 1'b0; reject_o = 1'b0; end
          ST_OPEN:  begin unlock_o = 1'b1; reject_o = 1'b0; end
          ST_DENY:  begin unlock_o = 1'b0; reject_o = 1'b1; end
          default:  begin unlock_o = 1'b0; reject_o = 1'b0; end
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/duo_code_lock.sv
module duo_code_lock #(
  parameter bit ONE_HOT = 1'b0,
  parameter logic [1:0] KEY_A = 2'b01,
  parameter logic [1:0] KEY_B = 2'b11
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       strobe_i,
  input  logic [1:0] digit_i,
  output logic       unlock_o,
  output logic       reject_o
);
  localparam int DW = 2;

  logic hit_a, hit_b;

  initial begin
    if (KEY_A == KEY_B) $error("duo_code_lock: KEY_A and KEY_B must differ (R10)");
  end

  duo_code_match #(.DW(DW), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_match (
    .digit_i (digit_i),
    .hit_a_o (hit_a),
    .hit_b_o (hit_b)
  );

  duo_code_seq #(.ONE_HOT(ONE_HOT)) u_seq (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .strobe_i (strobe_i),
    .hit_a_i  (hit_a),
    .hit_b_i  (hit_b),
    .unlock_o (unlock_o),
    .reject_o (reject_o)
  );
endmodule

// File: rtl/duo_code_lock_chk.sv
module duo_code_lock_chk #(
  parameter logic [1:0] KEY_A = 2'b01,
  parameter logic [1:0] KEY_B = 2'b11
) (
  input logic       clk_i,
  input logic       rst_i,
  input logic       strobe_i,
  input logic [1:0] digit_i,
  input logic       unlock_o,
  input logic       reject_o
);
  logic [1:0] strobes_q;
  logic       live_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      strobes_q <= 2'd0;
      live_q <= 1'b1;
    end else if (strobe_i && strobes_q != 2'd2) begin
      strobes_q <= strobes_q + 2'd1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk_i)
    rst_i |=> (!unlock_o && !reject_o));

  p_exclusive_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    live_q |-> !(unlock_o && reject_o));

  p_early_quiet_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (live_q && strobes_q < 2'd2) |-> (!unlock_o && !reject_o));

  p_hold_unlock_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (live_q && unlock_o) |=> unlock_o);

  p_hold_reject_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (live_q && reject_o) |=> reject_o);

  p_quiet_stable_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (live_q && !strobe_i) |=> ($stable(unlock_o) && $stable(reject_o)));
endmodule

bind duo_code_lock duo_code_lock_chk #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .strobe_i(strobe_i), .digit_i(digit_i),
  .unlock_o(unlock_o), .reject_o(reject_o)
);

// File: tb/duo_code_lock_tb_top.sv
module duo_code_lock_tb_top;
  localparam logic [1:0] KA = 2'b01;
  localparam logic [1:0] KB = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stb = 1'b0;
  logic [1:0] dig = 2'b00;
  logic un_b, rj_b, un_h, rj_h;

  int n_run = 0;
  int n_fail = 0;
  int ref_st = 0;
  int seed;
  bit done = 1'b0;

  always #10 clk = ~clk;

  duo_code_lock #(.ONE_HOT(1'b0), .KEY_A(KA), .KEY_B(KB)) dut_i (
    .clk_i(clk), .rst_i(rst), .strobe_i(stb), .digit_i(dig),
    .unlock_o(un_b), .reject_o(rj_b));

  duo_code_lock #(.ONE_HOT(1'b1), .KEY_A(KA), .KEY_B(KB)) dut_oh_i (
    .clk_i(clk), .rst_i(rst), .strobe_i(stb), .digit_i(dig),
    .unlock_o(un_h), .reject_o(rj_h));

  // Reference states: 0 idle, 1 good1, 2 fail1, 3 open, 4 deny
  function automatic int next_st(int s, bit r, bit st, logic [1:0] d);
    if (r) return 0;
    if (!st) return s;
    case (s)
      0: return (d == KA) ? 1 : 2;
      1: return (d == KB) ? 3 : 4;
      2: return 4;
      default: return s;
    endcase
  endfunction

  task automatic check(string req, int want_st);
    bit eu, er;
    eu = (want_st == 3);
    er = (want_st == 4);
    n_run++;
    if (un_b !== eu || rj_b !== er) begin
      n_fail++;
      $display("FAIL %s binary: got unlock=%0b reject=%0b exp %0b %0b", req, un_b, rj_b, eu, er);
    end
    n_run++;
    if (un_h !== eu || rj_h !== er) begin
      n_fail++;
      $display("FAIL %s onehot R10: got unlock=%0b reject=%0b exp %0b %0b", req, un_h, rj_h, eu, er);
    end
  endtask

  // drive one cycle, update model, sample mid-cycle after edge
  task automatic step(bit r, bit s, logic [1:0] d, string req);
    rst = r; stb = s; dig = d;
    @(posedge clk);
    ref_st = next_st(ref_st, r, s, d);
    #5;
    check(req, ref_st);
  endtask

  initial begin
    seed = 7;
    void'($urandom(seed));
    @(negedge clk);
    step(1, 0, 0, "R1");
    // correct code
    step(0, 0, KA, "R7");
    step(0, 1, KA, "R2");
    step(0, 0, 2'b00, "R7");
    step(0, 1, KB, "R4");
    step(0, 1, 2'b00, "R8");
    step(0, 1, KA, "R8");
    // wrong second
    step(1, 0, 0, "R1");
    step(0, 1, KA, "R2");
    step(0, 1, 2'b10, "R5");
    step(0, 1, KB, "R8");
    // wrong first, right second still rejected
    step(1, 0, 0, "R1");
    step(0, 1, 2'b00, "R3");
    step(0, 0, KB, "R7");
    step(0, 1, KB, "R6");
    // wrong first with KA as second
    step(1, 0, 0, "R1");
    step(0, 1, KB, "R3");
    step(0, 1, KA, "R6");
    // second digit equal to KA in good1 -> reject
    step(1, 0, 0, "R1");
    step(0, 1, KA, "R2");
    step(0, 1, KA, "R5");
    // reset mid-sequence
    step(0, 1, KA, "R8");
    step(1, 1, KA, "R1");
    step(0, 1, KA, "R2");
    // random
    for (int i = 0; i < 3000; i++) begin
      bit r;
      r = ($urandom % 12) == 0;
      step(r, $urandom % 2, 2'($urandom % 4), "R9");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hang exp finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule